// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Space Decoder

This block sits on the bus of a 16-bit processor running in its simple single-processor mode. On that bus, the low sixteen lines carry an address during the address phase and data afterwards. The four upper lines carry address bits first and status later. A strobe marks the address phase. The block captures the 20-bit address and the high-byte enable on that strobe, and holds them for the rest of the access. It then turns the processor's read and write lines into separate strobes for memory and for I/O, using the memory-or-I/O select line.

The same captured address feeds two parameterised range decoders. One serves the memory banks and compares all 20 bits. The other serves the I/O port windows and compares the low 16 bits. Each decoder raises at most one active-high select, and only while a read or write strobe is active in its space. When windows overlap, the lowest index wins. Each device has its own wait-state count. The ready output stays low for that many cycles at the start of the access, and an access that hits no device is released at once. The block also drives the byte-lane enables and the direction and enable of the data transceiver.

Top module: `cpu_bus_decoder`

## Requirements
- R1: The 20-bit address output is loaded from {ast_in[3:0], ad_in[15:0]} at each rising clock edge where `ale` is 1. It stays unchanged at every edge where `ale` is 0, even though the shared lines then carry data and status.
- R2: With `m_io`=1, an active-low `rd_n` or `wr_n` shows up only on `mem_rd_n` or `mem_wr_n`. With `m_io`=0 it shows up only on `io_rd_n` or `io_wr_n`. All four strobes are high when no access is active.
- R3: During an active strobe, `lane_lo` is 1 when the captured A0 is 0, and `lane_hi` is 1 when the captured high-byte enable (active low, taken during the address phase) is 0. Both are 0 outside an access. So BHE=0 with A0=0 is a word, BHE=0 with A0=1 is the odd byte, and BHE=1 with A0=0 is the even byte.
- R4: `xcvr_dir_tx` follows `dt_r` (1 = processor drives data out, 0 = processor receives). `xcvr_en` is 1 exactly while `rd_n` or `wr_n` is low.
- R5: `mem_sel[i]` is 1 only while a strobe is active with `m_io`=1 and the captured address A satisfies MEM_BASE[i] <= A < MEM_BASE[i]+MEM_SIZE[i]. The last address of a window selects the device, and the first address past it does not.
- R6: The I/O decoder compares all 16 port-address bits. Port 0x0040 and port 0x0140 reach different I/O windows.
- R7: When an access selects a device whose wait count is W, `ready` is 0 during the first W cycles of the strobe and 1 from cycle W onward. `ready` is 1 whenever no strobe is active.
- R8: An access that matches no window in its space raises no select, and `ready` is 1 in its first cycle.
- R9: When windows in one space overlap, only the lowest-indexed matching device is selected, and its wait count applies.
- R10: After a synchronous active-high reset, the address output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_in | input | 16 | Shared address/data lines |
| ast_in | input | 4 | Shared upper-address/status lines |
| ale | input | 1 | Address phase strobe, 1 = lines carry an address |
| bhe_n | input | 1 | High-byte enable, active low, valid during the address phase |
| m_io | input | 1 | Space select, 1 = memory, 0 = I/O |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dt_r | input | 1 | Transfer direction, 1 = processor transmits |
| addr | output | 20 | Captured address |
| lane_lo | output | 1 | Low byte lane enable |
| lane_hi | output | 1 | High byte lane enable |
| xcvr_en | output | 1 | Data transceiver enable |
| xcvr_dir_tx | output | 1 | Data transceiver direction, 1 = toward devices |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| mem_sel | output | N_MEM | Memory bank selects, active high |
| io_sel | output | N_IO | I/O window selects, active high |
| ready | output | 1 | Ready to the processor, 0 = insert a wait state |

## Verification
The assertions check the following on every cycle:
- the captured address does not move while `ale` is low;
- memory strobes never appear in an I/O cycle;
- selects appear only inside an active access of their own space, and no more than one at a time;
- an unmapped access is never stalled;
- `ready` drops on the first cycle of an access to a slow device and is high between accesses.

Only the bench's scenarios can show the rest:
- the exact decoding at window edges;
- that the I/O decoder tells ports apart when they differ only in the upper port byte;
- the overlap priority;
- the length of each wait-state run;
- the lane enables for word, odd-byte and even-byte transfers.

// File: rtl/bus_decode_pkg.sv
package bus_decode_pkg;

    localparam int unsigned BUS_W  = 16;
    localparam int unsigned HI_W   = 4;
    localparam int unsigned ADDR_W = BUS_W + HI_W;
    localparam int unsigned PORT_W = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              bhe_n;
    } addr_phase_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } lanes_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } strobes_t;

    function automatic lanes_t lane_enables(input logic bhe_n, input logic a0);
        lanes_t l;
        l.lo = ~a0;
        l.hi = ~bhe_n;
        return l;
    endfunction

    function automatic strobes_t split_strobes(input logic rd, input logic wr,
                                               input logic mem_space);
        strobes_t s;
        s.mem_rd = rd & mem_space;
        s.mem_wr = wr & mem_space;
        s.io_rd  = rd & ~mem_space;
        s.io_wr  = wr & ~mem_space;
        return s;
    endfunction

endpackage

// File: rtl/addr_phase_latch.sv
module addr_phase_latch
    import bus_decode_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ale,
    input  logic [BUS_W-1:0]    ad_in,
    input  logic [HI_W-1:0]     ast_in,
    input  logic                bhe_n,
    output addr_phase_t         held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held.addr  <= '0;
            held.bhe_n <= 1'b1;
        end else if (ale) begin
            held.addr  <= {ast_in, ad_in};
            held.bhe_n <= bhe_n;
        end
    end

    // R1: once the address phase is over the captured value must not move
    assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !ale |=> $stable(held));

endmodule

// File: rtl/range_decoder.sv
module range_decoder #(
    parameter int unsigned              AW   = 20,
    parameter int unsigned              N    = 2,
    parameter int unsigned              WSW  = 4,
    parameter logic [N*AW-1:0]          BASE = '0,
    parameter logic [N*AW-1:0]          SIZE = '0,
    parameter logic [N*WSW-1:0]         WS   = '0
) (
    input  logic [AW-1:0]   addr,
    input  logic            en,
    output logic [N-1:0]    sel,
    output logic [WSW-1:0]  ws
);

    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_win
            localparam logic [AW-1:0] B = BASE[i*AW +: AW];
            localparam logic [AW-1:0] S = SIZE[i*AW +: AW];
            logic [AW-1:0] offs;
            assign offs   = addr - B;
            assign hit[i] = en && (addr >= B) && (offs < S);
        end
    endgenerate

    // lowest index wins on overlap
    assign sel = hit & (~hit + 1'b1);

    always_comb begin
        ws = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) ws = ws | WS[i*WSW +: WSW];
        end
    end

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int unsigned WSW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic [WSW-1:0]  ws,
    output logic            ready
);

    logic [WSW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            elapsed <= '0;
        end else if (elapsed < ws) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign ready = !active || (elapsed >= ws);

    // R7: a slow device always costs at least one wait cycle at access start
    assert_wait_first_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(active) && ws != '0) |-> !ready);

    // R7: bus is never held between accesses
    assert_idle_ready_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> ready);

endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
    import bus_decode_pkg::*;
#(
    parameter int unsigned                  N_MEM    = 2,
    parameter int unsigned                  N_IO     = 3,
    parameter int unsigned                  WSW      = 4,
    parameter logic [N_MEM*ADDR_W-1:0]      MEM_BASE = {20'hF0000, 20'h00000},
    parameter logic [N_MEM*ADDR_W-1:0]      MEM_SIZE = {20'h10000, 20'h08000},
    parameter logic [N_MEM*WSW-1:0]         MEM_WS   = {4'd2, 4'd0},
    parameter logic [N_IO*PORT_W-1:0]       IO_BASE  = {16'h0140, 16'h0042, 16'h0040},
    parameter logic [N_IO*PORT_W-1:0]       IO_SIZE  = {16'h0010, 16'h0002, 16'h0004},
    parameter logic [N_IO*WSW-1:0]          IO_WS    = {4'd3, 4'd3, 4'd1}
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_W-1:0]     ad_in,
    input  logic [HI_W-1:0]      ast_in,
    input  logic                 ale,
    input  logic                 bhe_n,
    input  logic                 m_io,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic                 dt_r,
    output logic [ADDR_W-1:0]    addr,
    output logic                 lane_lo,
    output logic                 lane_hi,
    output logic                 xcvr_en,
    output logic                 xcvr_dir_tx,
    output logic                 mem_rd_n,
    output logic                 mem_wr_n,
    output logic                 io_rd_n,
    output logic                 io_wr_n,
    output logic [N_MEM-1:0]     mem_sel,
    output logic [N_IO-1:0]      io_sel,
    output logic                 ready
);

    addr_phase_t    held;
    strobes_t       stb;
    lanes_t         lanes;
    logic           xfer;
    logic [WSW-1:0] mem_ws;
    logic [WSW-1:0] io_ws;
    logic [WSW-1:0] ws_sel;

    addr_phase_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .ale    (ale),
        .ad_in  (ad_in),
        .ast_in (ast_in),
        .bhe_n  (bhe_n),
        .held   (held)
    );

    assign addr = held.addr;
    assign xfer = !rd_n || !wr_n;
    assign stb  = split_strobes(!rd_n, !wr_n, m_io);

    assign mem_rd_n = ~stb.mem_rd;
    assign mem_wr_n = ~stb.mem_wr;
    assign io_rd_n  = ~stb.io_rd;
    assign io_wr_n  = ~stb.io_wr;

    assign lanes   = lane_enables(held.bhe_n, held.addr[0]);
    assign lane_lo = xfer & lanes.lo;
    assign lane_hi = xfer & lanes.hi;

    assign xcvr_en     = xfer;
    assign xcvr_dir_tx = dt_r;

    range_decoder #(
        .AW   (ADDR_W),
        .N    (N_MEM),
        .WSW  (WSW),
        .BASE (MEM_BASE),
        .SIZE (MEM_SIZE),
        .WS   (MEM_WS)
    ) u_mem_dec (
        .addr (held.addr),
        .en   (xfer && m_io),
        .sel  (mem_sel),
        .ws   (mem_ws)
    );

    range_decoder #(
        .AW   (PORT_W),
        .N    (N_IO),
        .WSW  (WSW),
        .BASE (IO_BASE),
        .SIZE (IO_SIZE),
        .WS   (IO_WS)
    ) u_io_dec (
        .addr (held.addr[PORT_W-1:0]),
        .en   (xfer && !m_io),
        .sel  (io_sel),
        .ws   (io_ws)
    );

    assign ws_sel = m_io ? mem_ws : io_ws;

    wait_timer #(.WSW(WSW)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .active (xfer),
        .ws     (ws_sel),
        .ready  (ready)
    );

    // R2: a memory strobe never appears in an I/O cycle, nor the reverse
    assert_space_route_R2: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !mem_wr_n) |-> (m_io && (io_rd_n && io_wr_n)));

    // R5: memory selects only inside an active memory access
    assert_mem_sel_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (|mem_sel) |-> (xcvr_en && m_io));

    // R6: I/O selects only inside an active I/O access
    assert_io_sel_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (|io_sel) |-> (xcvr_en && !m_io));

    // R9: overlapping windows never produce two selects
    assert_sel_single_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_sel) && $onehot0(io_sel));

    // R8: an access that hits nothing is never stalled
    assert_unmapped_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (xcvr_en && !(|mem_sel) && !(|io_sel)) |-> ready);

    // R3: lane enables exist only inside an access
    assert_lanes_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !xcvr_en |-> (!lane_lo && !lane_hi));

endmodule

// File: tb/sim_cpu_bus_decoder.sv
module sim_cpu_bus_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ad_in = '0;
    logic [3:0]  ast_in = '0;
    logic        ale = 1'b0;
    logic        bhe_n = 1'b1;
    logic        m_io = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        dt_r = 1'b0;
    logic [19:0] addr;
    logic        lane_lo, lane_hi, xcvr_en, xcvr_dir_tx;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic [1:0]  mem_sel;
    logic [2:0]  io_sel;
    logic        ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    cpu_bus_decoder u0 (
        .clk(clk), .rst(rst), .ad_in(ad_in), .ast_in(ast_in), .ale(ale),
        .bhe_n(bhe_n), .m_io(m_io), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r),
        .addr(addr), .lane_lo(lane_lo), .lane_hi(lane_hi), .xcvr_en(xcvr_en),
        .xcvr_dir_tx(xcvr_dir_tx), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .mem_sel(mem_sel),
        .io_sel(io_sel), .ready(ready)
    );

    typedef struct packed {
        logic [19:0] a;
        logic        bhe_n;
        logic        mio;
        logic        wr;
        logic [1:0]  mem;
        logic [2:0]  io;
        logic        lo;
        logic        hi;
        logic [3:0]  ws;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{20'h00010, 1'b0, 1'b1, 1'b0, 2'b01, 3'b000, 1'b1, 1'b1, 4'd0}, // R5 word
        '{20'h07FFF, 1'b0, 1'b1, 1'b0, 2'b01, 3'b000, 1'b0, 1'b1, 4'd0}, // R5 last, odd byte
        '{20'h08000, 1'b1, 1'b1, 1'b1, 2'b00, 3'b000, 1'b1, 1'b0, 4'd0}, // R8 gap, even byte
        '{20'hF0000, 1'b0, 1'b1, 1'b0, 2'b10, 3'b000, 1'b1, 1'b1, 4'd2}, // R7 slow bank
        '{20'hFFFFF, 1'b0, 1'b1, 1'b1, 2'b10, 3'b000, 1'b0, 1'b1, 4'd2}, // R5 top byte
        '{20'h00040, 1'b0, 1'b0, 1'b0, 2'b00, 3'b001, 1'b1, 1'b1, 4'd1}, // R6 16-bit port
        '{20'h00140, 1'b1, 1'b0, 1'b1, 2'b00, 3'b100, 1'b1, 1'b0, 4'd3}, // R6 high port
        '{20'h00042, 1'b1, 1'b0, 1'b0, 2'b00, 3'b001, 1'b1, 1'b0, 4'd1}, // R9 overlap
        '{20'h00044, 1'b1, 1'b0, 1'b0, 2'b00, 3'b000, 1'b1, 1'b0, 4'd0}, // R8 no port
        '{20'h00040, 1'b0, 1'b1, 1'b1, 2'b01, 3'b000, 1'b1, 1'b1, 4'd0}, // R2 mem not io
        '{20'h0014F, 1'b0, 1'b0, 1'b0, 2'b00, 3'b100, 1'b0, 1'b1, 4'd3}  // R6 window end
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_access(input vec_t v);
        logic er, ew, ir, iw;
        er = v.mio & ~v.wr; ew = v.mio & v.wr;
        ir = ~v.mio & ~v.wr; iw = ~v.mio & v.wr;
        @(negedge clk);
        ale = 1'b1; ad_in = v.a[15:0]; ast_in = v.a[19:16];
        bhe_n = v.bhe_n; m_io = v.mio; dt_r = v.wr; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        ale = 1'b0; ad_in = 16'hA5A5; ast_in = 4'h5; bhe_n = 1'b1;
        if (v.wr) wr_n = 1'b0; else rd_n = 1'b0;
        #2;
        check("R1 addr held", 32'(addr), 32'(v.a));
        check("R2 strobes", {28'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
              {28'd0, ~er, ~ew, ~ir, ~iw});
        check("R3 lanes", {30'd0, lane_lo, lane_hi}, {30'd0, v.lo, v.hi});
        check("R4 xcvr", {30'd0, xcvr_en, xcvr_dir_tx}, {30'd0, 1'b1, v.wr});
        check("R5 mem_sel", 32'(mem_sel), 32'(v.mem));
        check("R6 io_sel", 32'(io_sel), 32'(v.io));
        check("R7 ready k0", 32'(ready), 32'(v.ws == 0));
        for (int k = 1; k <= int'(v.ws); k++) begin
            @(negedge clk); #2;
            check("R7 ready wait", 32'(ready), 32'(k >= int'(v.ws)));
        end
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        #2;
        check("R5 idle sel", {27'd0, mem_sel, io_sel}, 32'd0);
        check("R7 idle ready", 32'(ready), 32'd1);
        check("R3 idle lanes", {30'd0, lane_lo, lane_hi}, 32'd0);
        check("R4 idle xcvr", 32'(xcvr_en), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R10 reset addr", 32'(addr), 32'd0);
        check("R2 reset strobes", {28'd0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
              32'hF);
        check("R7 reset ready", 32'(ready), 32'd1);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_access(VEC[i]);

        // R1: data phase lines toggling while ale is low do not disturb addr
        @(negedge clk);
        ad_in = 16'h1234; ast_in = 4'hC;
        repeat (2) @(negedge clk);
        #2;
        check("R1 hold idle", 32'(addr), 32'h0014F);

        // R10: reset clears the captured address mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #2;
        check("R10 reset again", 32'(addr), 32'd0);
        rst = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule